// File: doc/BRIEF.md
# Four-Level Configuration Strap Capture and Decode

This block turns the sampled state of nine configuration strap pins into the static configuration of an Ethernet physical-layer device. An external comparator stage reduces each pin's voltage to a 2-bit level code for one of four levels. The block latches the nine codes when hardware reset is released. It latches them again when software requests a reset through a self-clearing bit in a small register port.

Each latched code passes through a per-pin mapping from level to two bits. The mappings differ from pin to pin and are not monotonic. A second decode layer then combines those bits into the following outputs:

- the 5-bit management address;
- the line mode: speed, duplex, autonegotiation advertisement and fiber;
- the MAC-side interface and its reference clock;
- the LED behaviour;
- several enables;
- flags for reserved or not-permitted strap settings.

Between capture events every output holds steady, whatever the pins do.

Top module: `strap_cfg_top`

## Requirements
- R1: While reset is low, the latch holds default levels. Pins 0, 5, 6 and 7 default to level 4; the others default to level 1. On the first rising edge with `rst_n` high, all nine codes are captured. Level code k-1 on `strap_lvl[2i+1:2i]` stands for level k of pin i.
- R2: A write to address 0x1F with data bit 15 set starts a software capture. In the cycle after the write, that bit reads back as 1. The codes are captured on the next edge, and the bit reads 0 one cycle after that capture.
- R3: Outside a capture, changing `strap_lvl` leaves every output unchanged.
- R4: Pin mappings give the pair (first, second) for levels 1/2/3/4:
  - pins 0, 2, 3, 6 and 7: 00/10/11/01;
  - pins 1 and 4: 10/00/01/11;
  - pin 8: 00/10/01/11.
- R5: `phy_addr` bit k is the second bit of pin k, for k from 0 to 4.
- R6: Pin 5 yields the duplex-select bit: 0 at level 1 and 1 at level 4. At level 2 or 3 it reads 0 and `strap_illegal` is 1.
- R7: When the first bit of pin 0 (fiber) is 1:
  - `fiber_en` is 1 and `speed_100` is 1;
  - `autoneg_en` is 0 and `adv_mask` is 0;
  - `full_duplex` follows the duplex-select bit.
- R8: With fiber off and the first bit of pin 4 (autoneg) at 0, the mode is forced:
  - `speed_100` equals the first bit of pin 1;
  - `full_duplex` equals the duplex-select bit;
  - `adv_mask` is 0.
- R9: With fiber off and autoneg set, `autoneg_en` is 1 while `speed_100` and `full_duplex` are 0. The `adv_mask` bits are:
  - bit 0 (10 half): always 1;
  - bit 1 (10 full): the duplex-select bit;
  - bit 2 (100 half): the pin 1 first bit;
  - bit 3 (100 full): both of those bits.
- R10: `mac_if` takes its value from the first bit of pin 7 and the two bits of pin 8 (pin 8's first bit is the 50 MHz select, its second is RMII):
  - 2 (RGMII, 25 MHz) when the pin 7 first bit is 1; the 50 MHz select is then reserved.
  - Otherwise 1 (RMII) when the pin 8 second bit is 1, with `ref_50m` equal to the pin 8 first bit.
  - Otherwise 0 (MII, 25 MHz), where the 50 MHz select is reserved.
  - `if_reserved` flags each reserved case.
- R11: The second bit of pin 7 drives `sig_det_en` when fiber is on, and drives `mdix_auto_en` when fiber is off.
- R12: `eee_en` is the first bit of pin 2 and `fastdrop_en` the first bit of pin 3. `led_speed` is the first bit of pin 6 and `led_link_only` its second bit.
- R13: A write to another address, or to 0x1F with bit 15 clear, starts no capture. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_lvl | input | 18 | Level codes, 2 bits per pin, pin i at [2i+1:2i] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| phy_addr | output | 5 | Management address |
| fiber_en | output | 1 | Fiber mode selected |
| autoneg_en | output | 1 | Autonegotiation enabled |
| speed_100 | output | 1 | 100 Mb/s in forced or fiber mode |
| full_duplex | output | 1 | Full duplex in forced or fiber mode |
| adv_mask | output | 4 | Advertised abilities {100F,100H,10F,10H} |
| mac_if | output | 2 | 0 MII, 1 RMII, 2 RGMII |
| ref_50m | output | 1 | 50 MHz reference clock selected |
| if_reserved | output | 1 | Reserved interface combination |
| strap_illegal | output | 1 | Duplex-select pin at a not-permitted level |
| eee_en | output | 1 | Energy-efficient mode enable |
| fastdrop_en | output | 1 | Fast link-drop enable |
| mdix_auto_en | output | 1 | Automatic crossover enable |
| sig_det_en | output | 1 | Fiber signal-detect enable |
| led_speed | output | 1 | LED speed-indication select |
| led_link_only | output | 1 | LED link-only select |

## Verification
The bench builds the block with its default parameters:

- a 5-bit address port;
- a 16-bit data port;
- the reset control at address 0x1F, bit 15.

With these settings, each pin mapping can be driven at all four levels. The duplex-select pin can also be placed at its two forbidden levels. Every branch of the mode table and of the interface table, including each reserved corner, can then be reached from the pins.

The default address makes the software capture sequence observable cycle by cycle through the read port. It also lets the bench show that writes to a neighbouring address are ignored.

// File: rtl/strap_pkg.sv
// Package strap_pkg
// Purpose: shared pin indices, level-to-bit mappings and per-pin defaults
//          for the strap capture block.
// Assumes: a level code of k-1 stands for level k; decoded pairs are held
//          as {first, second} in bits [1:0].
package strap_pkg;

    localparam int unsigned STRAP_PINS = 9;
    localparam int unsigned LVL_W      = 2;

    // pin roles (index into the level bus)
    localparam int unsigned IDX_FIBER_AD0  = 0;
    localparam int unsigned IDX_SPD_AD1    = 1;
    localparam int unsigned IDX_EEE_AD2    = 2;
    localparam int unsigned IDX_DROP_AD3   = 3;
    localparam int unsigned IDX_ANEN_AD4   = 4;
    localparam int unsigned IDX_DUPLEX     = 5;
    localparam int unsigned IDX_LED        = 6;
    localparam int unsigned IDX_IFSEL_MDIX = 7;
    localparam int unsigned IDX_CLK_RMII   = 8;

    typedef enum logic [1:0] {
        MAP_GRAY  = 2'd0,   // 00,10,11,01
        MAP_SHIFT = 2'd1,   // 10,00,01,11
        MAP_SWAP  = 2'd2,   // 00,10,01,11
        MAP_EDGE  = 2'd3    // {illegal, level4}
    } strap_map_e;

    typedef enum logic [1:0] {
        MAC_MII   = 2'd0,
        MAC_RMII  = 2'd1,
        MAC_RGMII = 2'd2
    } mac_sel_e;

    // which mapping each pin uses
    function automatic strap_map_e pin_map(input int unsigned idx);
        case (idx)
            IDX_SPD_AD1, IDX_ANEN_AD4: return MAP_SHIFT;
            IDX_CLK_RMII:              return MAP_SWAP;
            IDX_DUPLEX:                return MAP_EDGE;
            default:                   return MAP_GRAY;
        endcase
    endfunction

    // level code held while reset is asserted (pull-up pins sit at level 4)
    function automatic logic [1:0] pin_default(input int unsigned idx);
        case (idx)
            IDX_FIBER_AD0, IDX_DUPLEX, IDX_LED, IDX_IFSEL_MDIX: return 2'b11;
            default:                                           return 2'b00;
        endcase
    endfunction

    // level code -> {first, second}
    function automatic logic [1:0] map_level(input strap_map_e m, input logic [1:0] code);
        logic [1:0] r;
        case (m)
            MAP_GRAY:  r = {code[0] ^ code[1], code[1]};
            MAP_SHIFT: r = {code[0] ~^ code[1], code[1]};
            MAP_SWAP:  r = {code[0], code[1]};
            default:   r = {code[0] ^ code[1], code[0] & code[1]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/strap_capture_ctrl.sv
// Module strap_capture_ctrl
// Purpose: decides when the strap levels are latched: once on the first
//          edge after hardware reset, and once per software reset request
//          written through the register port. Holds the self-clearing bit.
// Assumes: single-cycle writes; reads are combinational on the address.
module strap_capture_ctrl #(
    parameter int unsigned REG_AW     = 5,
    parameter int unsigned REG_DW     = 16,
    parameter logic [REG_AW-1:0] SWRST_ADDR = 5'h1F,
    parameter int unsigned SWRST_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              sw_pend,
    output logic              cap_en
);

    localparam logic [REG_DW-1:0] RST_MASK = REG_DW'(1) << SWRST_BIT;

    logic hw_done;
    logic sw_done;
    logic wr_hit;
    logic wdata_unused;

    assign wdata_unused = ^(reg_wdata & ~RST_MASK);
    assign wr_hit = reg_wr && (reg_addr == SWRST_ADDR) && reg_wdata[SWRST_BIT];
    assign cap_en = !hw_done || (sw_pend && !sw_done);

    // remember that the post-reset capture has happened
    always_ff @(posedge clk) begin
        if (!rst_n) hw_done <= 1'b0;
        else        hw_done <= 1'b1;
    end

    // self-clearing reset bit: set by write, cleared one cycle after capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend <= 1'b0;
            sw_done <= 1'b0;
        end else begin
            sw_done <= sw_pend && !sw_done;
            if (wr_hit)       sw_pend <= 1'b1;
            else if (sw_done) sw_pend <= 1'b0;
        end
    end

    // read port: only the reset bit is implemented
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == SWRST_ADDR) reg_rdata = sw_pend ? RST_MASK : '0;
    end

endmodule

// File: rtl/strap_level_latch.sv
// Module strap_level_latch
// Purpose: one capture register per strap pin, reset to that pin's default
//          level, followed by that pin's level-to-bits mapping.
// Assumes: cap_en is a one-cycle strobe from the capture controller.
module strap_level_latch
    import strap_pkg::*;
#(
    parameter int unsigned NPINS = STRAP_PINS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic [NPINS*LVL_W-1:0] lvl_in,
    output logic [NPINS*2-1:0]     dec_bits
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam logic [1:0]  DEF = pin_default(i);
        localparam strap_map_e  MAP = pin_map(i);
        logic [LVL_W-1:0] lvl_q;

        // hold the level code between capture events
        always_ff @(posedge clk) begin
            if (!rst_n)      lvl_q <= DEF;
            else if (cap_en) lvl_q <= lvl_in[i*LVL_W +: LVL_W];
        end

        // per-pin mapping to {first, second}
        assign dec_bits[2*i +: 2] = map_level(MAP, lvl_q);
    end

endmodule

// File: rtl/strap_cfg_resolve.sv
// Module strap_cfg_resolve
// Purpose: second decode layer: combines decoded strap bits into address,
//          line mode, advertisement, MAC interface, LED and enable outputs.
// Assumes: dec_bits is stable between captures; purely combinational.
module strap_cfg_resolve
    import strap_pkg::*;
(
    input  logic [STRAP_PINS*2-1:0] dec_bits,
    output logic [4:0]              phy_addr,
    output logic                    fiber_en,
    output logic                    autoneg_en,
    output logic                    speed_100,
    output logic                    full_duplex,
    output logic [3:0]              adv_mask,
    output logic [1:0]              mac_if,
    output logic                    ref_50m,
    output logic                    if_reserved,
    output logic                    strap_illegal,
    output logic                    eee_en,
    output logic                    fastdrop_en,
    output logic                    mdix_auto_en,
    output logic                    sig_det_en,
    output logic                    led_speed,
    output logic                    led_link_only
);

    logic fx, an_en, spd_sel, dup_sel, rgmii_sel, rmii_sel, clk50, aux_bit;

    assign fx        = dec_bits[2*IDX_FIBER_AD0+1];
    assign spd_sel   = dec_bits[2*IDX_SPD_AD1+1];
    assign an_en     = dec_bits[2*IDX_ANEN_AD4+1];
    assign dup_sel   = dec_bits[2*IDX_DUPLEX];
    assign rgmii_sel = dec_bits[2*IDX_IFSEL_MDIX+1];
    assign aux_bit   = dec_bits[2*IDX_IFSEL_MDIX];
    assign clk50     = dec_bits[2*IDX_CLK_RMII+1];
    assign rmii_sel  = dec_bits[2*IDX_CLK_RMII];

    // address is the second bit of the five address-carrying pins
    for (genvar k = 0; k < 5; k++) begin : g_addr
        assign phy_addr[k] = dec_bits[2*k];
    end

    assign strap_illegal = dec_bits[2*IDX_DUPLEX+1];
    assign eee_en        = dec_bits[2*IDX_EEE_AD2+1];
    assign fastdrop_en   = dec_bits[2*IDX_DROP_AD3+1];
    assign led_speed     = dec_bits[2*IDX_LED+1];
    assign led_link_only = dec_bits[2*IDX_LED];

    // line mode: fiber overrides, then forced or advertised copper
    always_comb begin
        fiber_en    = fx;
        autoneg_en  = 1'b0;
        speed_100   = 1'b0;
        full_duplex = 1'b0;
        adv_mask    = 4'b0000;
        if (fx) begin
            speed_100   = 1'b1;
            full_duplex = dup_sel;
        end else if (!an_en) begin
            speed_100   = spd_sel;
            full_duplex = dup_sel;
        end else begin
            autoneg_en  = 1'b1;
            adv_mask    = {spd_sel & dup_sel, spd_sel, dup_sel, 1'b1};
        end
    end

    // MAC interface and reference clock, with reserved corners flagged
    always_comb begin
        ref_50m     = 1'b0;
        if_reserved = 1'b0;
        if (rgmii_sel) begin
            mac_if      = MAC_RGMII;
            if_reserved = clk50;
        end else if (rmii_sel) begin
            mac_if      = MAC_RMII;
            ref_50m     = clk50;
        end else begin
            mac_if      = MAC_MII;
            if_reserved = clk50;
        end
    end

    // shared bit: signal detect for fiber, crossover for copper
    assign sig_det_en   = aux_bit & fx;
    assign mdix_auto_en = aux_bit & ~fx;

endmodule

// File: rtl/strap_cfg_top.sv
// Module strap_cfg_top
// Purpose: captures nine four-level strap codes and decodes them into the
//          device's static configuration; exposes the software reset bit.
// Assumes: level codes come from an external comparator stage and are
//          already synchronous to clk.
module strap_cfg_top
    import strap_pkg::*;
#(
    parameter int unsigned REG_AW     = 5,
    parameter int unsigned REG_DW     = 16,
    parameter logic [REG_AW-1:0] SWRST_ADDR = 5'h1F,
    parameter int unsigned SWRST_BIT  = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [STRAP_PINS*LVL_W-1:0] strap_lvl,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [REG_DW-1:0]           reg_wdata,
    output logic [REG_DW-1:0]           reg_rdata,
    output logic [4:0]                  phy_addr,
    output logic                        fiber_en,
    output logic                        autoneg_en,
    output logic                        speed_100,
    output logic                        full_duplex,
    output logic [3:0]                  adv_mask,
    output logic [1:0]                  mac_if,
    output logic                        ref_50m,
    output logic                        if_reserved,
    output logic                        strap_illegal,
    output logic                        eee_en,
    output logic                        fastdrop_en,
    output logic                        mdix_auto_en,
    output logic                        sig_det_en,
    output logic                        led_speed,
    output logic                        led_link_only
);

    logic                    cap_en;
    logic                    sw_pend;
    logic [STRAP_PINS*2-1:0] dec_bits;

    strap_capture_ctrl #(
        .REG_AW(REG_AW), .REG_DW(REG_DW),
        .SWRST_ADDR(SWRST_ADDR), .SWRST_BIT(SWRST_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sw_pend(sw_pend), .cap_en(cap_en)
    );

    strap_level_latch #(.NPINS(STRAP_PINS)) u_latch (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
        .lvl_in(strap_lvl), .dec_bits(dec_bits)
    );

    strap_cfg_resolve u_resolve (
        .dec_bits(dec_bits), .phy_addr(phy_addr), .fiber_en(fiber_en),
        .autoneg_en(autoneg_en), .speed_100(speed_100),
        .full_duplex(full_duplex), .adv_mask(adv_mask), .mac_if(mac_if),
        .ref_50m(ref_50m), .if_reserved(if_reserved),
        .strap_illegal(strap_illegal), .eee_en(eee_en),
        .fastdrop_en(fastdrop_en), .mdix_auto_en(mdix_auto_en),
        .sig_det_en(sig_det_en), .led_speed(led_speed),
        .led_link_only(led_link_only)
    );

endmodule

// File: rtl/strap_cfg_chk.sv
// Module strap_cfg_chk
// Purpose: protocol and consistency properties of strap_cfg_top, bound in.
// Assumes: observes the capture strobe and pending bit inside the top.
module strap_cfg_chk #(
    parameter int unsigned REG_AW     = 5,
    parameter int unsigned REG_DW     = 16,
    parameter logic [REG_AW-1:0] SWRST_ADDR = 5'h1F,
    parameter int unsigned SWRST_BIT  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic              sw_pend,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic [4:0]        phy_addr,
    input logic              fiber_en,
    input logic              autoneg_en,
    input logic [3:0]        adv_mask,
    input logic [1:0]        mac_if,
    input logic              ref_50m,
    input logic              sig_det_en,
    input logic              mdix_auto_en
);

    logic wr_hit;
    assign wr_hit = reg_wr && (reg_addr == SWRST_ADDR) && reg_wdata[SWRST_BIT];

    // R3
    hold_between_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(phy_addr) && $stable(mac_if) && $stable(fiber_en) && $stable(adv_mask)));

    // R2
    swrst_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> sw_pend);

    // R2
    swrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pend && !cap_en && !wr_hit) |=> !sw_pend);

    // R2
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && sw_pend) |=> (!cap_en && sw_pend));

    // R7
    fiber_no_an_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_en |-> (!autoneg_en && adv_mask == 4'b0000));

    // R9
    adv_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        autoneg_en |-> adv_mask[0]);

    // R10
    iface_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_if != 2'b11) && (!ref_50m || mac_if == 2'b01));

    // R11
    aux_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sig_det_en, mdix_auto_en}) && (!sig_det_en || fiber_en));

endmodule

bind strap_cfg_top strap_cfg_chk #(
    .REG_AW(REG_AW), .REG_DW(REG_DW),
    .SWRST_ADDR(SWRST_ADDR), .SWRST_BIT(SWRST_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .sw_pend(sw_pend),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .phy_addr(phy_addr), .fiber_en(fiber_en), .autoneg_en(autoneg_en),
    .adv_mask(adv_mask), .mac_if(mac_if), .ref_50m(ref_50m),
    .sig_det_en(sig_det_en), .mdix_auto_en(mdix_auto_en)
);

// File: tb/tb_strap_cfg_top.sv
// Directed bench for strap_cfg_top: one task per scenario.
module tb_strap_cfg_top;

    localparam logic [1:0] M1 = 2'b00, M2 = 2'b01, M3 = 2'b10, M4 = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h1F;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  p0, p1, p2, p3, p4, p5, p6, p7, p8;
    logic [17:0] strap_lvl;
    logic [4:0]  phy_addr;
    logic        fiber_en, autoneg_en, speed_100, full_duplex;
    logic [3:0]  adv_mask;
    logic [1:0]  mac_if;
    logic        ref_50m, if_reserved, strap_illegal, eee_en, fastdrop_en;
    logic        mdix_auto_en, sig_det_en, led_speed, led_link_only;

    int n_tests = 0;
    int n_fail  = 0;

    assign strap_lvl = {p8, p7, p6, p5, p4, p3, p2, p1, p0};

    always #2 clk = ~clk;

    strap_cfg_top dut (
        .clk(clk), .rst_n(rst_n), .strap_lvl(strap_lvl), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .phy_addr(phy_addr), .fiber_en(fiber_en), .autoneg_en(autoneg_en),
        .speed_100(speed_100), .full_duplex(full_duplex), .adv_mask(adv_mask),
        .mac_if(mac_if), .ref_50m(ref_50m), .if_reserved(if_reserved),
        .strap_illegal(strap_illegal), .eee_en(eee_en),
        .fastdrop_en(fastdrop_en), .mdix_auto_en(mdix_auto_en),
        .sig_det_en(sig_det_en), .led_speed(led_speed),
        .led_link_only(led_link_only)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pins(input logic [1:0] a0, a1, a2, a3, a4, a5, a6, a7, a8);
        p0 = a0; p1 = a1; p2 = a2; p3 = a3; p4 = a4;
        p5 = a5; p6 = a6; p7 = a7; p8 = a8;
    endtask

    // software capture; returns after the bit has self-cleared
    task automatic sw_capture();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h1F; reg_wdata = 16'h8000;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_defaults();
        pins(M1, M1, M1, M1, M1, M1, M1, M1, M1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "default addr", phy_addr, 5'b00001);
        chk("R1", "default autoneg", autoneg_en, 1);
        chk("R1", "default adv", adv_mask, 4'b1111);
        chk("R1", "default mdix", mdix_auto_en, 1);
        chk("R1", "default led", {led_speed, led_link_only}, 2'b01);
        chk("R1", "default iface", mac_if, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "captured addr", phy_addr, 5'b00000);
        chk("R1", "captured adv", adv_mask, 4'b0101);
        chk("R4", "level1 aux bit", mdix_auto_en, 0);
        chk("R2", "bit15 idle", reg_rdata, 16'h0000);
    endtask

    task automatic t_address_and_swrst();
        pins(M4, M3, M3, M4, M4, M1, M2, M1, M1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h1F; reg_wdata = 16'h8000;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        chk("R2", "bit15 after write", reg_rdata, 16'h8000);
        chk("R2", "no capture yet", phy_addr, 5'b00000);
        @(negedge clk);
        chk("R2", "captured next edge", phy_addr, 5'b11111);
        chk("R2", "bit15 during capture cycle", reg_rdata, 16'h8000);
        @(negedge clk);
        chk("R2", "bit15 self-cleared", reg_rdata, 16'h0000);
        chk("R5", "address all ones", phy_addr, 5'b11111);
        chk("R12", "eee/fastdrop", {eee_en, fastdrop_en}, 2'b10);
        chk("R12", "led level2", {led_speed, led_link_only}, 2'b10);
        chk("R9", "adv base only", adv_mask, 4'b0001);
        pins(M1, M1, M1, M3, M1, M1, M1, M1, M1);
        sw_capture();
        chk("R4", "gray level3 pin3", {fastdrop_en, phy_addr[3]}, 2'b11);
        chk("R4", "shift level1 pins1/4", {phy_addr[1], phy_addr[4], autoneg_en}, 3'b001);
    endtask

    task automatic t_forced();
        for (int k = 0; k < 4; k++) begin
            logic a1, a0;
            a1 = k[1]; a0 = k[0];
            pins(M1, a1 ? M1 : M2, M1, M1, M2, a0 ? M4 : M1, M1, M1, M1);
            sw_capture();
            chk("R8", "forced autoneg", autoneg_en, 0);
            chk("R8", "forced speed/duplex", {speed_100, full_duplex}, {a1, a0});
            chk("R8", "forced adv", adv_mask, 0);
        end
    endtask

    task automatic t_advert();
        for (int k = 0; k < 4; k++) begin
            logic a1, a0;
            a1 = k[1]; a0 = k[0];
            pins(M1, a1 ? M1 : M2, M1, M1, M1, a0 ? M4 : M1, M1, M1, M1);
            sw_capture();
            chk("R9", "adv mask", adv_mask, {a1 & a0, a1, a0, 1'b1});
            chk("R9", "an speed/duplex", {autoneg_en, speed_100, full_duplex}, 3'b100);
        end
    endtask

    task automatic t_fiber();
        pins(M2, M1, M1, M1, M1, M4, M1, M4, M1);
        sw_capture();
        chk("R7", "fiber flags", {fiber_en, autoneg_en, speed_100, full_duplex}, 4'b1011);
        chk("R7", "fiber adv", adv_mask, 0);
        chk("R11", "sigdet/mdix fiber", {sig_det_en, mdix_auto_en}, 2'b10);
        pins(M2, M1, M1, M1, M1, M1, M1, M4, M1);
        sw_capture();
        chk("R7", "fiber half", full_duplex, 0);
        pins(M1, M1, M1, M1, M1, M1, M1, M4, M1);
        sw_capture();
        chk("R11", "sigdet/mdix copper", {sig_det_en, mdix_auto_en}, 2'b01);
    endtask

    task automatic t_led_illegal();
        pins(M1, M2, M1, M1, M2, M2, M1, M1, M1);
        sw_capture();
        chk("R6", "level2 flagged", {strap_illegal, full_duplex}, 2'b10);
        p5 = M3;
        sw_capture();
        chk("R6", "level3 flagged", {strap_illegal, full_duplex}, 2'b10);
        p5 = M4;
        sw_capture();
        chk("R6", "level4 legal", {strap_illegal, full_duplex}, 2'b01);
    endtask

    task automatic t_iface();
        logic [1:0] rx[7]  = '{M1, M1, M1, M1, M2, M2, M3};
        logic [1:0] dv[7]  = '{M1, M2, M3, M4, M1, M2, M4};
        logic [3:0] exp[7] = '{4'b00_0_0, 4'b00_0_1, 4'b01_0_0, 4'b01_1_0,
                               4'b10_0_0, 4'b10_0_1, 4'b10_0_1};
        for (int k = 0; k < 7; k++) begin
            pins(M1, M1, M1, M1, M1, M1, M1, rx[k], dv[k]);
            sw_capture();
            chk("R10", $sformatf("iface case %0d", k), {mac_if, ref_50m, if_reserved}, exp[k]);
        end
    endtask

    task automatic t_hold_and_ignore();
        // last state: RGMII, reserved, address 0
        pins(M3, M3, M3, M3, M3, M3, M3, M3, M3);
        repeat (5) @(negedge clk);
        chk("R3", "hold addr", phy_addr, 0);
        chk("R3", "hold iface", {mac_if, if_reserved, fiber_en}, 4'b1010);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h1E; reg_wdata = 16'hFFFF;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R13", "other addr reads 0", reg_rdata, 0);
        repeat (3) @(negedge clk);
        chk("R13", "other addr no capture", phy_addr, 0);
        reg_addr = 5'h1F; reg_wr = 1'b1; reg_wdata = 16'h7FFF;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R13", "bit15 clear not set", reg_rdata, 0);
        repeat (3) @(negedge clk);
        chk("R13", "bit15 clear no capture", {phy_addr, fiber_en}, 6'b000000);
    endtask

    task automatic t_led_cfg();
        pins(M1, M1, M1, M1, M1, M1, M3, M1, M1);
        sw_capture();
        chk("R12", "led level3", {led_speed, led_link_only}, 2'b11);
        p6 = M4;
        sw_capture();
        chk("R12", "led level4", {led_speed, led_link_only}, 2'b01);
    endtask

    task automatic t_hw_recapture();
        @(negedge clk);
        rst_n = 1'b0;
        pins(M4, M3, M3, M4, M4, M1, M1, M1, M4);
        repeat (2) @(negedge clk);
        chk("R1", "reset default again", phy_addr, 5'b00001);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "hw recapture addr", phy_addr, 5'b11111);
        chk("R10", "hw recapture iface", {mac_if, ref_50m}, 3'b011);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_defaults();
        t_address_and_swrst();
        t_forced();
        t_advert();
        t_fiber();
        t_led_illegal();
        t_iface();
        t_hold_and_ignore();
        t_led_cfg();
        t_hw_recapture();
        finish_run();
    end

endmodule